// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product in the same cycle. It has no clock and no state. A grid of AND gates forms every partial-product bit at once. Rows of adder cells then reduce those bits. Each row takes the sum bits of the row above, shifted by one column, and the carries of the row above, held in their own column. A final ripple row merges the carries and sums that are left into the upper half of the product.

The `FORM` parameter selects one of two cell layouts, and both give the same product. In the trimmed layout, the first row is AND gates only and the second row uses half adders. This brings the adder count down to (N-1)² full adders plus N-1 half adders. In the regular layout, the first two rows use the same full-adder cell as every other row, and the inputs those rows do not need are tied to zero. This gives one cell that can be tiled across the whole array.

Top module: `amul_array`

## Requirements
- R1: With `FORM` set to `FORM_TRIMMED` (row 0 is AND gates only and row 1 uses half adders), `prod_o` equals `x_i * y_i` as a 2N-bit unsigned value for every pair of operands.
- R2: With `FORM` set to `FORM_REGULAR` (every row uses full-adder cells and unused inputs are tied to zero), `prod_o` equals `x_i * y_i` for every pair of operands.
- R3: Bit 0 of `prod_o` equals the AND of bit 0 of `x_i` and bit 0 of `y_i`.
- R4: If either operand is zero, `prod_o` is zero.
- R5: Bit 2N-1 of `prod_o` can be set only when bit N-1 of both operands is set. Both operands at their largest value (2^N-1) give (2^N-1)², which is 0xE1 for N=4.
- R6: If one operand is 1, `prod_o` equals the other operand, zero-extended to 2N bits.
- R7: If `x_i` = 2^a and `y_i` = 2^b, `prod_o` has exactly one bit set, at position a+b.
- R8: The two forms give identical products for every pair of operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Multiplicand, unsigned |
| y_i | input | N | Multiplier, unsigned |
| prod_o | output | 2N | Unsigned product |

## Verification
The case that is hardest to reach from the ports is a carry that travels the longest path. It starts in the low columns of the array, goes down through every row, and then runs the full length of the final ripple row. Only a small set of operand pairs does this, such as two all-ones operands. A carry that is lost in a half-adder cell of the trimmed layout also shows up only for a few pairs. For these reasons the bench sweeps every operand pair through instances of both layouts side by side. Directed cases then cover the extreme values, the identity cases and the single-bit operands, and each directed case names its own requirement.

// File: rtl/amul_pkg.sv
// Package: types shared by the array multiplier modules.
// Assumes: nothing outside this file.
package amul_pkg;

    // Layout of the first two rows of the array.
    typedef enum logic {
        FORM_TRIMMED = 1'b0,  // row 0 AND-only, row 1 half adders
        FORM_REGULAR = 1'b1   // all rows full-adder cells, unused inputs tied to 0
    } amul_form_e;

    // Adder content of one array cell.
    typedef enum logic [1:0] {
        CELL_AND  = 2'd0,
        CELL_HALF = 2'd1,
        CELL_FULL = 2'd2
    } amul_cell_e;

endpackage

// File: rtl/amul_fa.sv
// Module: one-bit full adder.
// Assumes: purely combinational use; the inputs carry equal weight.
module amul_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);

    logic axb;

    // Purpose: sum from the XOR of all three inputs, carry from majority.
    always_comb begin
        axb  = a_i ^ b_i;
        s_o  = axb ^ c_i;
        co_o = (a_i & b_i) | (c_i & axb);
    end

    // Purpose: the two outputs must together equal the count of ones at the inputs.
    always_comb begin
        assert_fa_count_R1: assert ({co_o, s_o} == (2'(a_i) + 2'(b_i) + 2'(c_i)))
            else $error("full adder output does not equal count of ones at inputs");
    end

endmodule

// File: rtl/amul_cell.sv
// Module: one array cell. It ANDs its multiplicand and multiplier bits and
//         adds the result to the sum from above and the carry from the upper right.
// Assumes: KIND picks the adder content. A CELL_AND cell gets zero on both
//          incoming buses, and a CELL_HALF cell gets zero carry-in.
module amul_cell
    import amul_pkg::*;
#(
    parameter amul_cell_e KIND = CELL_FULL
) (
    input  logic x_bit,
    input  logic y_bit,
    input  logic sum_in,
    input  logic carry_in,
    output logic sum_out,
    output logic carry_out
);

    logic pp;

    // Purpose: form the partial-product bit for this cell.
    always_comb pp = x_bit & y_bit;

    generate
        if (KIND == CELL_FULL) begin : g_full
            amul_fa u_fa (
                .a_i (pp),
                .b_i (sum_in),
                .c_i (carry_in),
                .s_o (sum_out),
                .co_o(carry_out)
            );
        end else if (KIND == CELL_HALF) begin : g_half
            // Purpose: add two bits without a carry input.
            always_comb begin
                sum_out   = pp ^ sum_in;
                carry_out = pp & sum_in;
            end
            // Purpose: a half-adder cell must never receive a carry from the row above.
            always_comb begin
                assert_half_no_carry_R1: assert (carry_in == 1'b0)
                    else $error("half-adder cell received a carry");
            end
        end else begin : g_and
            // Purpose: pass the partial product and produce no carry.
            always_comb begin
                sum_out   = pp;
                carry_out = 1'b0;
            end
            // Purpose: an AND-only cell must get no sum and no carry to add in.
            always_comb begin
                assert_and_inputs_idle_R1: assert ((sum_in == 1'b0) && (carry_in == 1'b0))
                    else $error("AND-only cell received a non-zero adder input");
            end
        end
    endgenerate

endmodule

// File: rtl/amul_merge_row.sv
// Module: final ripple row. It adds the sum vector and carry vector that
//         leave the last array row and produces the upper product bits.
// Assumes: the vectors are aligned by weight at the inputs; ripple carry-in is 0.
module amul_merge_row #(
    parameter int W = 3
) (
    input  logic [W-1:0] sum_vec,
    input  logic [W-1:0] carry_vec,
    output logic [W:0]   res_o
);

    logic [W:0] rip;

    // Purpose: start the ripple chain with no carry.
    always_comb rip[0] = 1'b0;

    generate
        for (genvar k = 0; k < W; k++) begin : g_bit
            amul_fa u_fa (
                .a_i (sum_vec[k]),
                .b_i (carry_vec[k]),
                .c_i (rip[k]),
                .s_o (res_o[k]),
                .co_o(rip[k+1])
            );
        end
    endgenerate

    // Purpose: the carry out of the chain becomes the top result bit.
    always_comb res_o[W] = rip[W];

endmodule

// File: rtl/amul_array.sv
// Module: top of the combinational N x N unsigned array multiplier.
// Assumes: N >= 2. No clock and no reset (pure combinational datapath).
//          Row j handles multiplier bit j. In each row, column N-1 only passes
//          its partial product, and columns 0..N-2 add.
module amul_array
    import amul_pkg::*;
#(
    parameter int         N    = 4,
    parameter amul_form_e FORM = FORM_TRIMMED
) (
    input  logic [N-1:0]   x_i,
    input  logic [N-1:0]   y_i,
    output logic [2*N-1:0] prod_o
);

    localparam int PW = 2 * N;
    localparam int MW = N - 1;

    logic [N-1:0] s_row [N];
    logic [N-1:0] c_row [N];
    logic [MW:0]  merge_res;
    logic [MW-1:0] merge_sum;
    logic [MW-1:0] merge_car;

    generate
        for (genvar j = 0; j < N; j++) begin : g_row
            for (genvar i = 0; i < N; i++) begin : g_col
                localparam amul_cell_e KIND =
                    (j == 0) ? ((FORM == FORM_TRIMMED) ? CELL_AND : CELL_FULL) :
                    (i == N-1) ? CELL_AND :
                    (j == 1) ? ((FORM == FORM_TRIMMED) ? CELL_HALF : CELL_FULL) :
                    CELL_FULL;
                logic sin;
                logic cin;
                if ((j == 0) || (i == N-1)) begin : g_edge
                    // Purpose: tie the unused inputs of top-row and top-column cells to zero.
                    always_comb begin
                        sin = 1'b0;
                        cin = 1'b0;
                    end
                end else begin : g_inner
                    // Purpose: take the sum from one column up and the carry from the same column of the row above.
                    always_comb begin
                        sin = s_row[j-1][i+1];
                        cin = c_row[j-1][i];
                    end
                end
                amul_cell #(.KIND(KIND)) u_cell (
                    .x_bit    (x_i[i]),
                    .y_bit    (y_i[j]),
                    .sum_in   (sin),
                    .carry_in (cin),
                    .sum_out  (s_row[j][i]),
                    .carry_out(c_row[j][i])
                );
            end
        end
    endgenerate

    // Purpose: align the last row's remaining sums and carries for the merge row.
    always_comb begin
        for (int k = 0; k < MW; k++) begin
            merge_sum[k] = s_row[N-1][k+1];
            merge_car[k] = c_row[N-1][k];
        end
    end

    amul_merge_row #(.W(MW)) u_merge (
        .sum_vec  (merge_sum),
        .carry_vec(merge_car),
        .res_o    (merge_res)
    );

    // Purpose: lower bits come from column 0 of each row, upper bits from the merge row.
    always_comb begin
        for (int j = 0; j < N; j++) prod_o[j] = s_row[j][0];
        prod_o[PW-1:N] = merge_res;
    end

    // Purpose: check the assembled product against the arithmetic reference and its corner rules.
    always_comb begin
        assert_product_R1: assert (prod_o == (PW'(x_i) * PW'(y_i)))
            else $error("product differs from arithmetic reference");
        assert_bit0_R3: assert (prod_o[0] == (x_i[0] & y_i[0]))
            else $error("product bit 0 wrong");
        assert_zero_operand_R4: assert (!((x_i == '0) || (y_i == '0)) || (prod_o == '0))
            else $error("zero operand gave non-zero product");
        assert_top_bit_R5: assert (!prod_o[PW-1] || (x_i[N-1] && y_i[N-1]))
            else $error("top product bit set without both operand MSBs");
        for (int j = 0; j < N; j++) begin
            assert_edge_no_carry_R2: assert (c_row[j][N-1] == 1'b0)
                else $error("top-column cell produced a carry");
        end
    end

endmodule

// File: tb/amul_array_tb.sv
// Bench: directed tests of both layouts of the array multiplier, one task per scenario.
module amul_array_tb_top;
    import amul_pkg::*;

    localparam int N          = 4;
    localparam int PW         = 2 * N;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  xa, ya;
    logic [PW-1:0] p_trim, p_reg;
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amul_array #(.N(N), .FORM(FORM_TRIMMED)) dut_i (
        .x_i(xa), .y_i(ya), .prod_o(p_trim)
    );

    amul_array #(.N(N), .FORM(FORM_REGULAR)) dut_reg_i (
        .x_i(xa), .y_i(ya), .prod_o(p_reg)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s x=%0d y=%0d actual=%0h expected=%0h", req, xa, ya, act, exp);
        end
    endtask

    // Drive operands away from the clock edge and let the combinational array settle.
    task automatic apply(input int a, input int b);
        @(negedge clk);
        xa = N'(a);
        ya = N'(b);
        #1;
    endtask

    task automatic t_reset_state;
        apply(0, 0);
        check("R4 reset-idle trimmed", p_trim, '0);
        check("R4 reset-idle regular", p_reg, '0);
    endtask

    task automatic t_exhaustive;
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                logic [PW-1:0] exp;
                exp = PW'(a) * PW'(b);
                apply(a, b);
                check("R1 trimmed product", p_trim, exp);
                check("R2 regular product", p_reg, exp);
                check("R8 forms agree", p_trim, p_reg);
                check("R3 bit0", {{(PW-1){1'b0}}, p_trim[0]}, {{(PW-1){1'b0}}, xa[0] & ya[0]});
                if (p_trim[PW-1] && !(xa[N-1] && ya[N-1]))
                    check("R5 top bit needs both MSBs", p_trim, '0);
            end
        end
    endtask

    task automatic t_zero;
        for (int v = 0; v <= MAXV; v++) begin
            apply(0, v);
            check("R4 zero multiplicand", p_trim, '0);
            apply(v, 0);
            check("R4 zero multiplier", p_reg, '0);
        end
    endtask

    task automatic t_max;
        apply(MAXV, MAXV);
        check("R5 max x max trimmed", p_trim, PW'(8'hE1));
        check("R5 max x max regular", p_reg, PW'(8'hE1));
        apply(MAXV, (1 << (N-1)) - 1);
        check("R5 top bit clear without y MSB", {{(PW-1){1'b0}}, p_trim[PW-1]}, '0);
    endtask

    task automatic t_identity;
        for (int v = 0; v <= MAXV; v++) begin
            apply(v, 1);
            check("R6 times one (y=1)", p_trim, PW'(v));
            apply(1, v);
            check("R6 times one (x=1)", p_reg, PW'(v));
        end
    endtask

    task automatic t_pow2;
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                apply(1 << a, 1 << b);
                check("R7 single bit trimmed", p_trim, PW'(1) << (a + b));
                check("R7 single bit regular", p_reg, PW'(1) << (a + b));
            end
        end
    endtask

    initial begin
        xa = '0;
        ya = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        t_reset_state();
        t_exhaustive();
        t_zero();
        t_max();
        t_identity();
        t_pow2();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule